// File: doc/BRIEF.md
# Buffered Serial Flash Block Writer

This block sits between a fixed-rate mono audio source and the data line of a removable flash card. Incoming 16-bit PCM samples are gathered into one half of a two-bank on-chip store. Once a bank holds a whole block, that bank is shifted out one bit at a time on the card data line. The frame is a start bit, the payload, a 16-bit CRC and an end bit. The writer then reads a short response token from the card and waits until the card releases its busy indication. While one bank drains, the other bank collects the next block.

The card command set and the initialization sequence are handled elsewhere. This block only sees two status inputs, card present and initialization done, and stays silent until both are high. A mode input selects how writes are grouped. In single mode every block opens its own write operation. In multi mode consecutive blocks share one open operation, and that operation stays open until the mode input returns low. If the card disappears mid-transfer, the transfer is abandoned and all buffered audio is discarded, so the card never stores data that is partial or out of order.

Top module: `flash_block_writer`

## Requirements
- R1: While `cardPresent` or `cardInitDone` is low, incoming samples are dropped and `cardDataOe` stays low. A sample that arrived in that state never appears in any later frame.
- R2: A frame starts only when a bank holds `BLOCK_SAMPLES` samples. A partly filled bank produces no activity on the card line.
- R3: The frame is sent MSB first, one bit per serial clock period, in this order: a 0 start bit, the samples in arrival order (each sample MSB first), the 16 CRC bits, and a 1 end bit. `cardDataOe` is high for exactly the frame bits.
- R4: The CRC uses polynomial x^16+x^12+x^5+1 (0x1021) with initial value 0. It is computed over the payload bits only, in the order they are sent.
- R5: `opStart` pulses once for each write operation. In single mode (`multiMode`=0) that is once per block. In multi mode it pulses once for a run of blocks, and `opOpen` stays high between them until `multiMode` falls.
- R6: After the end bit, the writer samples a 3-bit token from `cardDataIn` on three serial clock rises, MSB first. Token 010 increments `blockCount`. Any other token sets the sticky `crcErr` and leaves the count unchanged.
- R7: After the token, the writer keeps `xferBusy` high and starts no new frame while `cardDataIn` is low. It finishes at the first serial clock rise on which `cardDataIn` is high.
- R8: If the filling bank completes while the other bank is still pending or being written, the new block is dropped whole and the sticky `overrunErr` is set. The block sent next is the first one filled after that.
- R9: Losing card readiness during a transfer clears `cardDataOe` on the next cycle and sets the sticky `abortErr`. It also discards every buffered sample. The next frame holds only samples that arrive after readiness returns.
- R10: The serial clock `cardClk` is low while idle. Data changes on its falling edge and is stable at its rising edge. Each half period lasts `HALF_CYCLES` system clocks.
- R11: A synchronous active-high `rst` clears both banks, `blockCount` and all flags. It also returns `cardClk` low and `cardDataOe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleValid | input | 1 | One-cycle strobe marking a new sample |
| sampleData | input | SAMPLE_W | PCM sample value |
| cardPresent | input | 1 | Card inserted |
| cardInitDone | input | 1 | Card initialization finished |
| multiMode | input | 1 | 1 = stream blocks in one operation, 0 = one operation per block |
| cardDataIn | input | 1 | Card data line as seen by the writer (token and busy) |
| cardClk | output | 1 | Serial clock to the card |
| cardDataOut | output | 1 | Serial data driven to the card |
| cardDataOe | output | 1 | Drive enable for cardDataOut |
| opStart | output | 1 | Pulse at the start of a write operation |
| opOpen | output | 1 | A write operation is in progress |
| xferBusy | output | 1 | Frame, token or card-busy phase active |
| crcErr | output | 1 | Sticky: a block received a non-accept token |
| overrunErr | output | 1 | Sticky: a completed block was dropped |
| abortErr | output | 1 | Sticky: a transfer was cut by card loss |
| blockCount | output | SEQ_W | Number of blocks accepted by the card |

## Verification
The hardest case to reach is an overrun. A whole second block has to finish filling while the first is still on the wire, which never happens at the intended sample rate. The bench therefore sends eight samples two cycles apart, and then shows that the next frame carries the third block and not the dropped second one. The card-loss case is similar. Readiness is pulled away a few dozen cycles into a frame, and the following frame must contain only samples sent after recovery. A small card model drives the token and the busy period from the serial clock edges.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic startBlock;   // load first word of the read bank, clear CRC
    logic stepData;     // fold current payload bit into CRC, advance
    logic stepCrc;      // shift CRC register by one bit
    logic releaseBlock; // read bank written, hand it back to the filler
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_TOKEN = 2'd2,
    ST_BUSY  = 2'd3
  } wrState_t;

  // One serial step of CRC-16 with generator 0x1021
  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

endpackage

// File: rtl/fbw_datapath.sv
module fbw_datapath
  import fbw_pkg::*;
#(
  parameter int SAMPLE_W      = 16,
  parameter int BLOCK_SAMPLES = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cardReady,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  dpStrobe_t           strobe,
  output logic                blockReady,
  output logic                dataBit,
  output logic                crcBit,
  output logic                overrunErr
);

  localparam int ADDR_W = $clog2(BLOCK_SAMPLES);
  localparam int BIT_W  = $clog2(SAMPLE_W);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BLOCK_SAMPLES - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] mem [2][BLOCK_SAMPLES];
  logic [1:0]          full;
  logic                fillBuf;
  logic                rdBuf;
  logic [ADDR_W-1:0]   fillCnt;
  logic [ADDR_W-1:0]   wordIdx;
  logic [ADDR_W-1:0]   nextIdx;
  logic [BIT_W-1:0]    bitCnt;
  logic [SAMPLE_W-1:0] shiftReg;
  logic [15:0]         crcReg;

  assign nextIdx    = (wordIdx == LAST_ADDR) ? '0 : wordIdx + 1'b1;
  assign blockReady = full[rdBuf];
  assign dataBit    = shiftReg[SAMPLE_W-1];
  assign crcBit     = crcReg[15];

  // Fill side: bank storage, fill pointer, bank ownership flags
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++) begin
        for (int w = 0; w < BLOCK_SAMPLES; w++) begin
          mem[b][w] <= '0;
        end
      end
      full       <= '0;
      fillBuf    <= 1'b0;
      rdBuf      <= 1'b0;
      fillCnt    <= '0;
      overrunErr <= 1'b0;
    end else if (!cardReady) begin
      full    <= '0;
      fillBuf <= 1'b0;
      rdBuf   <= 1'b0;
      fillCnt <= '0;
    end else begin
      if (sampleValid) begin
        mem[fillBuf][fillCnt] <= sampleData;
        if (fillCnt == LAST_ADDR) begin
          fillCnt <= '0;
          if (full[~fillBuf]) begin
            overrunErr <= 1'b1;
          end else begin
            full[fillBuf] <= 1'b1;
            fillBuf       <= ~fillBuf;
          end
        end else begin
          fillCnt <= fillCnt + 1'b1;
        end
      end
      if (strobe.releaseBlock) begin
        full[rdBuf] <= 1'b0;
        rdBuf       <= ~rdBuf;
      end
    end
  end

  // Drain side: word shifter and running CRC
  always_ff @(posedge clk) begin
    if (rst) begin
      wordIdx  <= '0;
      bitCnt   <= '0;
      shiftReg <= '0;
      crcReg   <= '0;
    end else if (strobe.startBlock) begin
      wordIdx  <= '0;
      bitCnt   <= '0;
      shiftReg <= mem[rdBuf][0];
      crcReg   <= '0;
    end else if (strobe.stepData) begin
      crcReg <= crcStep(crcReg, shiftReg[SAMPLE_W-1]);
      if (bitCnt == LAST_BIT) begin
        bitCnt   <= '0;
        wordIdx  <= nextIdx;
        shiftReg <= mem[rdBuf][nextIdx];
      end else begin
        bitCnt   <= bitCnt + 1'b1;
        shiftReg <= {shiftReg[SAMPLE_W-2:0], 1'b0};
      end
    end else if (strobe.stepCrc) begin
      crcReg <= {crcReg[14:0], 1'b0};
    end
  end

  // R8: the bank being filled is never one that awaits draining
  a_r8_fill_bank_free : assert property (@(posedge clk) disable iff (rst)
    !full[fillBuf]);

  // R8: overrun flag is sticky until reset
  a_r8_overrun_sticky : assert property (@(posedge clk) disable iff (rst)
    overrunErr |=> overrunErr);

  // R2: a block is only handed to the writer when it is complete
  a_r2_release_owned : assert property (@(posedge clk) disable iff (rst)
    strobe.releaseBlock |-> full[rdBuf]);

endmodule

// File: rtl/fbw_control.sv
module fbw_control
  import fbw_pkg::*;
#(
  parameter int SAMPLE_W      = 16,
  parameter int BLOCK_SAMPLES = 256,
  parameter int HALF_CYCLES   = 1,
  parameter int SEQ_W         = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cardReady,
  input  logic             multiMode,
  input  logic             cardDataIn,
  input  logic             blockReady,
  input  logic             dataBit,
  input  logic             crcBit,
  output dpStrobe_t        strobe,
  output logic             cardClk,
  output logic             cardDataOut,
  output logic             cardDataOe,
  output logic             opStart,
  output logic             opOpen,
  output logic             xferBusy,
  output logic             crcErr,
  output logic             abortErr,
  output logic [SEQ_W-1:0] blockCount
);

  localparam int DATA_BITS = BLOCK_SAMPLES * SAMPLE_W;
  localparam int END_IDX   = DATA_BITS + 17;
  localparam int IDX_W     = $clog2(END_IDX + 1);
  localparam int HC_W      = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [IDX_W-1:0] END_POS   = IDX_W'(END_IDX);
  localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_BITS);
  localparam logic [IDX_W-1:0] CRC_LAST  = IDX_W'(DATA_BITS + 16);
  localparam logic [HC_W-1:0]  HC_LAST   = HC_W'(HALF_CYCLES - 1);

  wrState_t         state;
  logic [HC_W-1:0]  halfCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] nextBit;
  logic [2:0]       token;
  logic [1:0]       tokCnt;
  logic             toggle;
  logic             riseEv;
  logic             fallEv;

  assign xferBusy = (state != ST_IDLE);
  assign toggle   = xferBusy && (halfCnt == HC_LAST);
  assign riseEv   = toggle && !cardClk;
  assign fallEv   = toggle && cardClk;
  assign nextBit  = bitIdx + 1'b1;

  always_comb begin
    strobe = '0;
    strobe.startBlock = (state == ST_IDLE) && cardReady && blockReady;
    if (state == ST_SEND && fallEv && bitIdx != END_POS) begin
      if (nextBit <= DATA_LAST) strobe.stepData = 1'b1;
      else if (nextBit <= CRC_LAST) strobe.stepCrc = 1'b1;
    end
    strobe.releaseBlock = (state == ST_BUSY) && riseEv && cardDataIn && cardReady;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      halfCnt     <= '0;
      bitIdx      <= '0;
      cardClk     <= 1'b0;
      cardDataOut <= 1'b1;
      cardDataOe  <= 1'b0;
      opStart     <= 1'b0;
      opOpen      <= 1'b0;
      crcErr      <= 1'b0;
      abortErr    <= 1'b0;
      blockCount  <= '0;
      token       <= '0;
      tokCnt      <= '0;
    end else begin
      opStart <= 1'b0;
      if (xferBusy && !cardReady) begin
        state       <= ST_IDLE;
        abortErr    <= 1'b1;
        cardClk     <= 1'b0;
        cardDataOe  <= 1'b0;
        cardDataOut <= 1'b1;
        opOpen      <= 1'b0;
        halfCnt     <= '0;
      end else begin
        if (xferBusy) begin
          halfCnt <= toggle ? '0 : halfCnt + 1'b1;
          if (toggle) cardClk <= ~cardClk;
        end
        case (state)
          ST_IDLE: begin
            cardClk <= 1'b0;
            halfCnt <= '0;
            if (strobe.startBlock) begin
              state       <= ST_SEND;
              bitIdx      <= '0;
              cardDataOe  <= 1'b1;
              cardDataOut <= 1'b0;
              opOpen      <= 1'b1;
              if (!(opOpen && multiMode)) opStart <= 1'b1;
            end else if (!multiMode || !cardReady) begin
              opOpen <= 1'b0;
            end
          end
          ST_SEND: begin
            if (fallEv) begin
              if (bitIdx == END_POS) begin
                state       <= ST_TOKEN;
                cardDataOe  <= 1'b0;
                cardDataOut <= 1'b1;
                tokCnt      <= '0;
              end else begin
                bitIdx <= nextBit;
                if (nextBit <= DATA_LAST) cardDataOut <= dataBit;
                else if (nextBit <= CRC_LAST) cardDataOut <= crcBit;
                else cardDataOut <= 1'b1;
              end
            end
          end
          ST_TOKEN: begin
            if (riseEv) begin
              token  <= {token[1:0], cardDataIn};
              tokCnt <= tokCnt + 1'b1;
              if (tokCnt == 2'd2) state <= ST_BUSY;
            end
          end
          ST_BUSY: begin
            if (riseEv && cardDataIn) begin
              state   <= ST_IDLE;
              cardClk <= 1'b0;
              if (token == 3'b010) blockCount <= blockCount + 1'b1;
              else crcErr <= 1'b1;
              if (!multiMode || token != 3'b010) opOpen <= 1'b0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: nothing is driven towards a card that is not ready
  a_r1_gate_on_ready : assert property (@(posedge clk) disable iff (rst)
    !cardReady |=> !cardDataOe);

  // R2: a frame begins only after the datapath reported a full bank
  a_r2_start_needs_block : assert property (@(posedge clk) disable iff (rst)
    $rose(cardDataOe) |-> $past(blockReady));

  // R3: data drive enable is confined to the frame phase
  a_r3_oe_in_frame : assert property (@(posedge clk) disable iff (rst)
    cardDataOe |-> state == ST_SEND);

  // R6: the accepted-block count only moves on leaving the busy phase
  a_r6_count_step : assert property (@(posedge clk) disable iff (rst)
    (blockCount != $past(blockCount)) |-> ($past(state) == ST_BUSY));

  // R9: abort leaves the data line released
  a_r9_abort_release : assert property (@(posedge clk) disable iff (rst)
    $rose(abortErr) |-> !cardDataOe);

  // R10: serial clock rests low whenever no transfer is active
  a_r10_clk_idle_low : assert property (@(posedge clk) disable iff (rst)
    !xferBusy |-> !cardClk);

endmodule

// File: rtl/flash_block_writer.sv
module flash_block_writer
  import fbw_pkg::*;
#(
  parameter int SAMPLE_W      = 16,
  parameter int BLOCK_SAMPLES = 256,
  parameter int HALF_CYCLES   = 1,
  parameter int SEQ_W         = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                cardPresent,
  input  logic                cardInitDone,
  input  logic                multiMode,
  input  logic                cardDataIn,
  output logic                cardClk,
  output logic                cardDataOut,
  output logic                cardDataOe,
  output logic                opStart,
  output logic                opOpen,
  output logic                xferBusy,
  output logic                crcErr,
  output logic                overrunErr,
  output logic                abortErr,
  output logic [SEQ_W-1:0]    blockCount
);

  logic      cardReady;
  logic      blockReady;
  logic      dataBit;
  logic      crcBit;
  dpStrobe_t strobe;

  assign cardReady = cardPresent && cardInitDone;

  fbw_datapath #(
    .SAMPLE_W      (SAMPLE_W),
    .BLOCK_SAMPLES (BLOCK_SAMPLES)
  ) uDatapath (
    .clk         (clk),
    .rst         (rst),
    .cardReady   (cardReady),
    .sampleValid (sampleValid),
    .sampleData  (sampleData),
    .strobe      (strobe),
    .blockReady  (blockReady),
    .dataBit     (dataBit),
    .crcBit      (crcBit),
    .overrunErr  (overrunErr)
  );

  fbw_control #(
    .SAMPLE_W      (SAMPLE_W),
    .BLOCK_SAMPLES (BLOCK_SAMPLES),
    .HALF_CYCLES   (HALF_CYCLES),
    .SEQ_W         (SEQ_W)
  ) uControl (
    .clk         (clk),
    .rst         (rst),
    .cardReady   (cardReady),
    .multiMode   (multiMode),
    .cardDataIn  (cardDataIn),
    .blockReady  (blockReady),
    .dataBit     (dataBit),
    .crcBit      (crcBit),
    .strobe      (strobe),
    .cardClk     (cardClk),
    .cardDataOut (cardDataOut),
    .cardDataOe  (cardDataOe),
    .opStart     (opStart),
    .opOpen      (opOpen),
    .xferBusy    (xferBusy),
    .crcErr      (crcErr),
    .abortErr    (abortErr),
    .blockCount  (blockCount)
  );

endmodule

// File: tb/tb_flash_block_writer.sv
`timescale 1ns/1ps
module tb_flash_block_writer;

  localparam int SW    = 16;
  localparam int NS    = 4;
  localparam int HC    = 2;
  localparam int FRAME = 1 + NS * SW + 16 + 1;
  localparam int GAP   = 120;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b0;
  logic [SW-1:0] sampleData = '0;
  logic cardPresent = 1'b1;
  logic cardInitDone = 1'b0;
  logic multiMode = 1'b0;
  logic cardDataIn = 1'b1;
  logic cardClk, cardDataOut, cardDataOe, opStart, opOpen, xferBusy;
  logic crcErr, overrunErr, abortErr;
  logic [15:0] blockCount;

  always #2 clk = ~clk;

  flash_block_writer #(.SAMPLE_W(SW), .BLOCK_SAMPLES(NS), .HALF_CYCLES(HC), .SEQ_W(16)) dut (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleData(sampleData),
    .cardPresent(cardPresent), .cardInitDone(cardInitDone), .multiMode(multiMode),
    .cardDataIn(cardDataIn), .cardClk(cardClk), .cardDataOut(cardDataOut),
    .cardDataOe(cardDataOe), .opStart(opStart), .opOpen(opOpen), .xferBusy(xferBusy),
    .crcErr(crcErr), .overrunErr(overrunErr), .abortErr(abortErr), .blockCount(blockCount));

  int checks = 0;
  int fails  = 0;

  // Card model and frame monitor
  logic             prevClk = 1'b0;
  int               capCnt = 0;
  logic [FRAME-1:0] capBits = '0;
  logic [FRAME-1:0] lastFrame = '0;
  int               frameCount = 0;
  int               opStarts = 0;
  int               oeCycles = 0;
  int               respPhase = 0;
  int               tokIdx = 0;
  int               busyLeft = 0;
  logic [2:0]       tokVal = 3'b010;
  int               busyLen = 2;

  always @(posedge clk) begin
    prevClk <= cardClk;
    if (opStart) opStarts <= opStarts + 1;
    if (cardDataOe) oeCycles <= oeCycles + 1;
    if (!cardDataOe) capCnt <= 0;
    if (cardClk && !prevClk && cardDataOe) begin
      if (capCnt == FRAME - 1) begin
        lastFrame  <= {capBits[FRAME-2:0], cardDataOut};
        frameCount <= frameCount + 1;
        capCnt     <= 0;
        respPhase  <= 1;
        tokIdx     <= 0;
        busyLeft   <= busyLen;
      end else begin
        capCnt <= capCnt + 1;
      end
      capBits <= {capBits[FRAME-2:0], cardDataOut};
    end
    if (!cardClk && prevClk && respPhase == 1) begin
      if (tokIdx < 3) begin
        cardDataIn <= tokVal[2 - tokIdx];
        tokIdx     <= tokIdx + 1;
      end else if (busyLeft > 0) begin
        cardDataIn <= 1'b0;
        busyLeft   <= busyLeft - 1;
      end else begin
        cardDataIn <= 1'b1;
        respPhase  <= 0;
      end
    end
    if (!xferBusy && respPhase == 0) cardDataIn <= 1'b1;
  end

  logic [SW-1:0] samp [NS];

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FRAME-1:0] expFrame();
    logic [15:0] c;
    logic [NS*SW-1:0] pay;
    c = 16'h0000;
    for (int i = 0; i < NS; i++) pay[(NS-1-i)*SW +: SW] = samp[i];
    for (int i = NS*SW-1; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ pay[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return {1'b0, pay, c, 1'b1};
  endfunction

  task automatic push(input logic [SW-1:0] v, input int gap);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleData  = v;
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pushBlock(input logic [SW-1:0] base, input int gap);
    for (int i = 0; i < NS; i++) begin
      samp[i] = base + SW'(i * 16'h0111);
      push(samp[i], gap);
    end
  endtask

  task automatic waitIdle(input int startFrames);
    int n = 0;
    while ((frameCount == startFrames || xferBusy) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic tReset();
    @(negedge clk);
    check(!cardDataOe && !cardClk, "R11 reset line", {cardDataOe, cardClk}, 0);
    check({crcErr, overrunErr, abortErr, opOpen} == 0, "R11 reset flags",
          {crcErr, overrunErr, abortErr, opOpen}, 0);
    check(blockCount == 0, "R11 reset count", blockCount, 0);
  endtask

  task automatic tNoCard();
    cardInitDone = 1'b0;
    for (int i = 0; i < 8; i++) push(16'hDEAD, 4);
    repeat (400) @(negedge clk);
    check(frameCount == 0 && oeCycles == 0, "R1 no drive before init", oeCycles, 0);
    cardInitDone = 1'b1;
  endtask

  task automatic tPartialThenFull();
    int f0 = frameCount;
    int o0 = opStarts;
    samp[0] = 16'hA5C3; push(samp[0], 10);
    samp[1] = 16'h0F0F; push(samp[1], 10);
    samp[2] = 16'h8001; push(samp[2], 10);
    repeat (600) @(negedge clk);
    check(frameCount == f0 && !cardDataOe, "R2 partial block held", frameCount, f0);
    samp[3] = 16'h7FFE; push(samp[3], 1);
    waitIdle(f0);
    check(lastFrame == expFrame(), "R3 R4 frame and CRC", lastFrame, expFrame());
    check(lastFrame[FRAME-1] == 1'b0 && lastFrame[0] == 1'b1, "R3 start/end bits",
          {lastFrame[FRAME-1], lastFrame[0]}, 2'b01);
    check(blockCount == 1, "R6 accepted count", blockCount, 1);
    check(opStarts == o0 + 1, "R5 single op start", opStarts, o0 + 1);
  endtask

  task automatic tSingleTwo();
    int o0 = opStarts;
    int f0;
    multiMode = 1'b0;
    f0 = frameCount; pushBlock(16'h1000, GAP); waitIdle(f0);
    f0 = frameCount; pushBlock(16'h2222, GAP); waitIdle(f0);
    check(lastFrame == expFrame(), "R3 second single frame", lastFrame, expFrame());
    check(opStarts == o0 + 2, "R5 one op per block in single mode", opStarts, o0 + 2);
    check(blockCount == 3, "R6 count after singles", blockCount, 3);
  endtask

  task automatic tMulti();
    int o0 = opStarts;
    int f0;
    multiMode = 1'b1;
    f0 = frameCount; pushBlock(16'h3030, GAP); waitIdle(f0);
    f0 = frameCount; pushBlock(16'h4141, GAP); waitIdle(f0);
    check(lastFrame == expFrame(), "R3 multi frame", lastFrame, expFrame());
    check(opStarts == o0 + 1, "R5 one op for multi run", opStarts, o0 + 1);
    check(opOpen == 1'b1, "R5 op stays open in multi", opOpen, 1);
    multiMode = 1'b0;
    repeat (4) @(negedge clk);
    check(opOpen == 1'b0, "R5 op closes on mode drop", opOpen, 0);
  endtask

  task automatic tBadToken();
    int f0 = frameCount;
    logic [15:0] c0 = blockCount;
    tokVal = 3'b011;
    pushBlock(16'h5A5A, GAP);
    waitIdle(f0);
    check(crcErr == 1'b1, "R6 bad token flags error", crcErr, 1);
    check(blockCount == c0, "R6 bad token not counted", blockCount, c0);
    tokVal = 3'b010;
  endtask

  task automatic tBusyHold();
    int f0 = frameCount;
    logic [15:0] c0 = blockCount;
    busyLen = 20;
    pushBlock(16'h6060, GAP);
    while (frameCount == f0) @(negedge clk);
    repeat (60) @(negedge clk);
    check(xferBusy && blockCount == c0, "R7 held while card busy", {xferBusy, blockCount}, {1'b1, c0});
    repeat (120) @(negedge clk);
    check(!xferBusy && blockCount == c0 + 1, "R7 released after busy", {xferBusy, blockCount},
          {1'b0, 16'(c0 + 1)});
    busyLen = 2;
  endtask

  task automatic tOverrun();
    int f0 = frameCount;
    logic [FRAME-1:0] frameA;
    pushBlock(16'h7100, 2);
    frameA = expFrame();
    pushBlock(16'h7200, 2);
    waitIdle(f0);
    check(overrunErr == 1'b1, "R8 overrun flagged", overrunErr, 1);
    check(lastFrame == frameA && frameCount == f0 + 1, "R8 first block sent", lastFrame, frameA);
    repeat (300) @(negedge clk);
    check(frameCount == f0 + 1, "R8 dropped block not sent", frameCount, f0 + 1);
    f0 = frameCount;
    pushBlock(16'h7300, GAP);
    waitIdle(f0);
    check(lastFrame == expFrame(), "R8 next block follows drop", lastFrame, expFrame());
  endtask

  task automatic tAbort();
    int f0 = frameCount;
    pushBlock(16'h8800, GAP);
    while (!cardDataOe) @(negedge clk);
    repeat (40) @(negedge clk);
    cardInitDone = 1'b0;
    repeat (2) @(negedge clk);
    check(!cardDataOe && abortErr, "R9 abort releases line", {cardDataOe, abortErr}, 2'b01);
    repeat (400) @(negedge clk);
    check(frameCount == f0, "R9 aborted frame incomplete", frameCount, f0);
    cardInitDone = 1'b1;
    pushBlock(16'h9900, GAP);
    waitIdle(f0);
    check(lastFrame == expFrame(), "R9 fresh data after recovery", lastFrame, expFrame());
  endtask

  task automatic tClockShape();
    int f0 = frameCount;
    int lowCnt = 0;
    int highCnt = 0;
    bit badChange = 0;
    logic pd, pc;
    pushBlock(16'hC0DE, GAP);
    while (!cardDataOe) @(negedge clk);
    pd = cardDataOut; pc = cardClk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cardDataOut != pd && !(pc && !cardClk)) badChange = 1;
      if (cardClk) highCnt++; else lowCnt++;
      pd = cardDataOut; pc = cardClk;
    end
    check(!badChange, "R10 data changes only at falling edge", badChange, 0);
    check(highCnt == 20 && lowCnt == 20, "R10 half period", highCnt, 20);
    waitIdle(f0);
    check(!cardClk, "R10 clock low when idle", cardClk, 0);
  endtask

  task automatic tResetClears();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check({crcErr, overrunErr, abortErr} == 0, "R11 reset clears flags",
          {crcErr, overrunErr, abortErr}, 0);
    check(blockCount == 0, "R11 reset clears count", blockCount, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tReset();
    tNoCard();
    tPartialThenFull();
    tSingleTwo();
    tMulti();
    tBadToken();
    tBusyHold();
    tOverrun();
    tAbort();
    tClockShape();
    tResetClears();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule